// File: doc/BRIEF.md
# Conversion Result Register with Overrun Flag

This block sits between an analog-to-digital conversion engine and a simple register bus. Each time the engine presents a result with a one-cycle valid strobe, the block holds the value in a data register and raises an end-of-conversion (EOC) flag. If a result arrives while EOC is still set, meaning the previous result was never consumed, the block raises a sticky overrun (OVR) flag. A control bit selects which result survives an overrun.

Software clears EOC by reading the data register or by writing a one to the EOC bit of the status register. OVR stays set until software writes a one to its own bit. A single interrupt output combines the two flags through per-flag enables. The block still records the overrun correctly when an EOC clear and a new result land in the same bus cycle.

Word addresses: 0 is the data register (read-only, result zero-extended), 1 is status (bit 0 EOC, bit 1 OVR, write-one-to-clear), 2 is control (bit 0 EOC interrupt enable, bit 1 OVR interrupt enable, bit 2 keep-old policy), and 3 reads as zero. The bus reads combinationally: `bus_rdata` is valid in the cycle in which `bus_en` is high and `bus_we` is low, and is zero otherwise. Writes and read side effects take effect at the clock edge that ends that cycle.

Top module: `convreg_top`

## Requirements
- R1: After reset, the status, data and control registers all read 0 and `irq` is 0.
- R2: A cycle with `conv_valid` high, while EOC is clear, loads `conv_data` into the data register and sets EOC (status bit 0) at the next edge.
- R3: A read of address 0 returns the held result in that same cycle and clears EOC at the closing edge.
- R4: Writing 1 to status bit 0 clears EOC. Writing 0 there leaves EOC unchanged.
- R5: A cycle with `conv_valid` high while EOC is set sets OVR (status bit 1), and EOC stays set.
- R6: OVR stays set through data reads and through writes of 0 to status bit 1. Only writing 1 to status bit 1 clears it.
- R7: On an overrun with control bit 2 = 0, the new result replaces the held one. With control bit 2 = 1, the held result is kept.
- R8: When an EOC clear (a data read or a status bit 0 write) coincides with `conv_valid` while EOC is set, OVR is set, EOC ends up set, and the data register takes the new result whatever the policy bit says.
- R9: `irq` is high exactly when (EOC and control bit 0) or (OVR and control bit 1) holds.
- R10: An overrun event in the same cycle as a write of 1 to status bit 1 leaves OVR set. Setting OVR wins over clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_valid | input | 1 | One-cycle strobe marking a new conversion result |
| conv_data | input | DATA_W | Conversion result |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational, zero when no read is in progress |
| irq | output | 1 | Combined interrupt request |

## Verification
The sharpest corner is a new result landing in the same cycle as an EOC clear. A design that let the clear mask the overrun would leave OVR low and silently lose a result. A design that let the clear win over the new result would leave EOC low, so the fresh data would look already consumed. The bench also targets the keep-old policy in that same coincident cycle, where a design that applied the policy blindly would discard the result that software had not yet seen. It further checks the set-versus-clear race on OVR, and that data reads and zero writes leave the sticky flag alone, since a careless decoder would drop OVR on any status access.

// File: rtl/convreg_pkg.sv
package convreg_pkg;

  // word addresses of the register file
  localparam int ADDR_DATA = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_CTRL = 2;

  // status bit positions
  localparam int STAT_EOC_BIT = 0;
  localparam int STAT_OVR_BIT = 1;

  // control bit positions
  localparam int CTRL_EOC_IE_BIT = 0;
  localparam int CTRL_OVR_IE_BIT = 1;
  localparam int CTRL_KEEP_BIT   = 2;
  localparam int CTRL_W          = 3;

  typedef struct packed {
    logic keep_old;
    logic ovr_ie;
    logic eoc_ie;
  } ctrl_t;

  typedef struct packed {
    logic rd_data;
    logic clr_eoc;
    logic clr_ovr;
    logic wr_ctrl;
  } bus_strb_t;

endpackage

// File: rtl/convreg_rst_sync.sv
module convreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sn = sh_q[STAGES-1];

endmodule

// File: rtl/convreg_bus_dec.sv
module convreg_bus_dec
  import convreg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int BUS_W  = 32
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output bus_strb_t         strb,
  output ctrl_t             ctrl_wval
);

  logic hit_data;
  logic hit_stat;
  logic hit_ctrl;
  logic rd_cyc;
  logic wr_cyc;
  logic unused_wbits;

  assign hit_data = (bus_addr == ADDR_W'(ADDR_DATA));
  assign hit_stat = (bus_addr == ADDR_W'(ADDR_STAT));
  assign hit_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
  assign rd_cyc   = bus_en & ~bus_we;
  assign wr_cyc   = bus_en & bus_we;

  always_comb begin
    strb.rd_data = rd_cyc & hit_data;
    strb.clr_eoc = wr_cyc & hit_stat & bus_wdata[STAT_EOC_BIT];
    strb.clr_ovr = wr_cyc & hit_stat & bus_wdata[STAT_OVR_BIT];
    strb.wr_ctrl = wr_cyc & hit_ctrl;
  end

  always_comb begin
    ctrl_wval.eoc_ie   = bus_wdata[CTRL_EOC_IE_BIT];
    ctrl_wval.ovr_ie   = bus_wdata[CTRL_OVR_IE_BIT];
    ctrl_wval.keep_old = bus_wdata[CTRL_KEEP_BIT];
  end

  assign unused_wbits = ^bus_wdata[BUS_W-1:CTRL_W];

endmodule

// File: rtl/convreg_flags.sv
module convreg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic new_res,
  input  logic clr_eoc,
  input  logic clr_ovr,
  output logic eoc_q,
  output logic ovr_q,
  output logic ovr_evt
);

  logic eoc_d;
  logic ovr_d;
  logic eoc_en;
  logic ovr_en;

  // an overrun is judged on the flag as it stood before this cycle,
  // so a clear landing in the same cycle cannot hide it
  assign ovr_evt = new_res & eoc_q;

  assign eoc_en = new_res | clr_eoc;
  assign ovr_en = ovr_evt | clr_ovr;

  always_comb begin
    eoc_d = eoc_q;
    if (clr_eoc) eoc_d = 1'b0;
    if (new_res) eoc_d = 1'b1;
  end

  always_comb begin
    ovr_d = ovr_q;
    if (clr_ovr) ovr_d = 1'b0;
    if (ovr_evt) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q <= 1'b0;
    end else if (eoc_en) begin
      eoc_q <= eoc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (ovr_en) begin
      ovr_q <= ovr_d;
    end
  end

endmodule

// File: rtl/convreg_data_hold.sv
module convreg_data_hold #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_res,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              ovr_evt,
  input  logic              clr_eoc,
  input  logic              keep_old,
  output logic [DATA_W-1:0] data_q
);

  logic              keep_held;
  logic              load_en;
  logic [DATA_W-1:0] data_d;

  // the held value is protected only while it is still unconsumed;
  // a clear in the same cycle means it was read or discarded already
  assign keep_held = ovr_evt & keep_old & ~clr_eoc;
  assign load_en   = new_res & ~keep_held;

  always_comb begin
    data_d = conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_en) begin
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/convreg_top.sv
module convreg_top
  import convreg_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 2,
  parameter int BUS_W     = 32,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);

  logic              rst_s;
  bus_strb_t         strb;
  ctrl_t             ctrl_wval;
  ctrl_t             ctrl_q;
  ctrl_t             ctrl_d;
  logic              eoc_q;
  logic              ovr_q;
  logic              ovr_evt;
  logic [DATA_W-1:0] data_q;
  logic [BUS_W-1:0]  data_word;
  logic [BUS_W-1:0]  stat_word;
  logic [BUS_W-1:0]  ctrl_word;
  logic [BUS_W-1:0]  rd_mux;

  convreg_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_s)
  );

  convreg_bus_dec #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .strb      (strb),
    .ctrl_wval (ctrl_wval)
  );

  convreg_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_s),
    .new_res (conv_valid),
    .clr_eoc (strb.clr_eoc | strb.rd_data),
    .clr_ovr (strb.clr_ovr),
    .eoc_q   (eoc_q),
    .ovr_q   (ovr_q),
    .ovr_evt (ovr_evt)
  );

  convreg_data_hold #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_s),
    .new_res   (conv_valid),
    .conv_data (conv_data),
    .ovr_evt   (ovr_evt),
    .clr_eoc   (strb.clr_eoc | strb.rd_data),
    .keep_old  (ctrl_q.keep_old),
    .data_q    (data_q)
  );

  // control register
  always_comb begin
    ctrl_d = ctrl_wval;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= '0;
    end else if (strb.wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  // result width adapted to the bus
  generate
    if (BUS_W > DATA_W) begin : g_pad
      assign data_word = {{(BUS_W-DATA_W){1'b0}}, data_q};
    end else begin : g_trunc
      assign data_word = data_q[BUS_W-1:0];
    end
  endgenerate

  always_comb begin
    stat_word               = '0;
    stat_word[STAT_EOC_BIT] = eoc_q;
    stat_word[STAT_OVR_BIT] = ovr_q;
    ctrl_word                  = '0;
    ctrl_word[CTRL_EOC_IE_BIT] = ctrl_q.eoc_ie;
    ctrl_word[CTRL_OVR_IE_BIT] = ctrl_q.ovr_ie;
    ctrl_word[CTRL_KEEP_BIT]   = ctrl_q.keep_old;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(ADDR_DATA)) rd_mux = data_word;
    if (bus_addr == ADDR_W'(ADDR_STAT)) rd_mux = stat_word;
    if (bus_addr == ADDR_W'(ADDR_CTRL)) rd_mux = ctrl_word;
  end

  assign bus_rdata = (bus_en & ~bus_we) ? rd_mux : '0;
  assign irq       = (eoc_q & ctrl_q.eoc_ie) | (ovr_q & ctrl_q.ovr_ie);

endmodule

// File: rtl/convreg_chk.sv
module convreg_chk #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_s,
  input logic              conv_valid,
  input logic [DATA_W-1:0] conv_data,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              irq,
  input logic              eoc_q,
  input logic              ovr_q,
  input logic [DATA_W-1:0] data_q,
  input logic              keep_old
);

  logic rd_data;
  logic wr_eoc1;
  logic wr_ovr1;
  logic any_clr;

  assign rd_data = bus_en && !bus_we && (bus_addr == ADDR_W'(0));
  assign wr_eoc1 = bus_en && bus_we && (bus_addr == ADDR_W'(1)) && bus_wdata[0];
  assign wr_ovr1 = bus_en && bus_we && (bus_addr == ADDR_W'(1)) && bus_wdata[1];
  assign any_clr = rd_data || wr_eoc1;

  // R2
  eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    conv_valid |=> eoc_q);

  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_s)
    conv_valid && !eoc_q |=> data_q == $past(conv_data));

  // R3
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rd_data && !conv_valid |=> !eoc_q);

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    conv_valid && eoc_q |=> ovr_q);

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ovr_q && !wr_ovr1 |=> ovr_q);

  // R7
  keep_old_chk: assert property (@(posedge clk) disable iff (!rst_s)
    conv_valid && eoc_q && keep_old && !any_clr |=> $stable(data_q));

  // R8
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_s)
    conv_valid && eoc_q && any_clr |=> eoc_q && ovr_q && data_q == $past(conv_data));

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !eoc_q && !ovr_q |-> !irq);

  // R10
  ovr_prio_chk: assert property (@(posedge clk) disable iff (!rst_s)
    conv_valid && eoc_q && wr_ovr1 |=> ovr_q);

endmodule

bind convreg_top convreg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .conv_valid (conv_valid),
  .conv_data  (conv_data),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .eoc_q      (eoc_q),
  .ovr_q      (ovr_q),
  .data_q     (data_q),
  .keep_old   (ctrl_q.keep_old)
);

// File: tb/sim_convreg_top.sv
`timescale 1ns/1ps
module sim_convreg_top;

  localparam int DW = 12;

  logic          clk;
  logic          rst_n;
  logic          conv_valid;
  logic [DW-1:0] conv_data;
  logic          bus_en;
  logic          bus_we;
  logic [1:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq;

  int n_run;
  int n_fail;
  bit done;

  convreg_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .conv_data  (conv_data),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all bus and conversion tasks start and end at a falling edge
  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    conv_valid = 1'b1; conv_data = d;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  // status read without side effects
  task automatic stat(output logic [31:0] v);
    rd(2'd1, v);
  endtask

  task automatic cleanup();
    logic [31:0] v;
    wr(2'd1, 32'h3);
    wr(2'd2, 32'h0);
    stat(v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    stat(v);       chk("R1 status", v, 32'h0);
    rd(2'd0, v);   chk("R1 data", v, 32'h0);
    rd(2'd2, v);   chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    push(12'hABC);
    stat(v);       chk("R2 eoc set", v, 32'h1);
    rd(2'd0, v);   chk("R2/R3 data", v, 32'hABC);
    stat(v);       chk("R3 eoc cleared by read", v, 32'h0);
    cleanup();
  endtask

  task automatic t_swclear();
    logic [31:0] v;
    push(12'h123);
    wr(2'd1, 32'h0);
    stat(v);       chk("R4 write zero ignored", v, 32'h1);
    wr(2'd1, 32'h1);
    stat(v);       chk("R4 write one clears", v, 32'h0);
    rd(2'd0, v);   chk("R4 data kept", v, 32'h123);
    cleanup();
  endtask

  task automatic t_ovr_overwrite();
    logic [31:0] v;
    push(12'h111);
    push(12'h222);
    stat(v);       chk("R5 overrun flagged", v, 32'h3);
    rd(2'd0, v);   chk("R7 overwrite policy", v, 32'h222);
    stat(v);       chk("R6 read leaves ovr", v, 32'h2);
    wr(2'd1, 32'h0);
    stat(v);       chk("R6 zero write leaves ovr", v, 32'h2);
    wr(2'd1, 32'h2);
    stat(v);       chk("R6 ovr cleared", v, 32'h0);
    cleanup();
  endtask

  task automatic t_ovr_keep();
    logic [31:0] v;
    wr(2'd2, 32'h4);
    push(12'h333);
    push(12'h444);
    stat(v);       chk("R5 keep overrun flagged", v, 32'h3);
    rd(2'd0, v);   chk("R7 keep policy", v, 32'h333);
    cleanup();
  endtask

  task automatic t_coin_read(input logic keep);
    logic [31:0] v;
    wr(2'd2, {29'b0, keep, 2'b00});
    push(12'h555);
    conv_valid = 1'b1; conv_data = 12'h666;
    rd(2'd0, v);
    conv_valid = 1'b0;
    chk("R3 coincident read value", v, 32'h555);
    stat(v);       chk("R8 read+new flags", v, 32'h3);
    rd(2'd0, v);   chk("R8 read+new data", v, 32'h666);
    cleanup();
  endtask

  task automatic t_coin_sw();
    logic [31:0] v;
    wr(2'd2, 32'h4);
    push(12'h101);
    conv_valid = 1'b1; conv_data = 12'h202;
    wr(2'd1, 32'h1);
    conv_valid = 1'b0;
    stat(v);       chk("R8 clear+new flags", v, 32'h3);
    rd(2'd0, v);   chk("R8 clear+new data", v, 32'h202);
    cleanup();
  endtask

  task automatic t_ovr_prio();
    logic [31:0] v;
    push(12'h0AA);
    push(12'h0BB);
    conv_valid = 1'b1; conv_data = 12'h0CC;
    wr(2'd1, 32'h2);
    conv_valid = 1'b0;
    stat(v);       chk("R10 set beats clear", v, 32'h3);
    cleanup();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    push(12'h010);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h1);
    chk("R9 eoc irq", {31'b0, irq}, 32'h1);
    rd(2'd0, v);
    chk("R9 eoc irq drops", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h2);
    push(12'h020);
    chk("R9 eoc only not enabled", {31'b0, irq}, 32'h0);
    push(12'h030);
    chk("R9 ovr irq", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h0);
    chk("R9 ovr irq disabled", {31'b0, irq}, 32'h0);
    cleanup();
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; conv_valid = 1'b0; conv_data = '0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_capture();
    t_swclear();
    t_ovr_overwrite();
    t_ovr_keep();
    t_coin_read(1'b0);
    t_coin_read(1'b1);
    t_coin_sw();
    t_ovr_prio();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule